// File: doc/BRIEF.md
# Eight-bit ALU with condition code register

This block pairs a purely combinational eight-bit arithmetic and logic unit with an eight-bit condition code register. Each cycle the ALU combines two operands under a three-bit operation select and drives the result straight out. When the flag-update enable is high, the register captures the negative, zero, signed-overflow, carry/borrow and half-carry flags that the operation produces. Which flags are captured depends on the operation.

The three control bits in the register are the stop disable, the non-maskable interrupt mask and the interrupt mask. The ALU never alters them. They change only through a direct write port, which loads the whole register in one cycle. The add-with-carry and subtract-with-borrow operations take their incoming carry from the stored C flag. Chained operations can therefore run over wider words, one byte per cycle.

Top module: `alu8_flagged`

## Requirements
- R1: After a cycle with `rst_n` low, the flag register reads 0xD0 (S, X and I set, all other flags clear).
- R2: The flag register bit order, from bit 7 down to bit 0, is S, X, H, I, N, Z, V, C.
- R3: `result` is combinational and follows `op_sel`. 0 gives A+B, 1 gives A+B+C, 2 gives A−B, 3 gives A−B−C, 4 gives A AND B, 5 gives A OR B, 6 gives A XOR B, and 7 passes A. Every result is modulo 256.
- R4: On a flag update, N takes bit 7 of the result, and Z is set exactly when the result is zero.
- R5: On an add or subtract, V is set exactly when the signed two's-complement result overflows.
- R6: On an add, C is the carry out of bit 7. On a subtract, C is set exactly when B, plus the incoming borrow for operation 3, exceeds A as unsigned numbers.
- R7: H is the carry out of bit 3, and it is written only by operations 0 and 1. Every other operation leaves H unchanged.
- R8: Operations 4 to 7 clear V and leave C and H unchanged.
- R9: In a cycle with `flag_en` low and `ccr_we` low, the flag register keeps its value.
- R10: S, X and I change only through `ccr_we`. A write loads all eight bits from `ccr_wdata` on the next edge. It wins over a flag update in the same cycle.
- R11: Operations 1 and 3 use the stored C flag as carry in or borrow in. Operations 0 and 2 ignore it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_a | input | 8 | First operand (minuend for subtracts) |
| opnd_b | input | 8 | Second operand (subtrahend for subtracts) |
| op_sel | input | 3 | Operation select, encoding in R3 |
| flag_en | input | 1 | Capture the operation's flags on this edge |
| ccr_we | input | 1 | Load the whole flag register from `ccr_wdata` |
| ccr_wdata | input | 8 | Value written on `ccr_we` |
| result | output | 8 | Combinational ALU result |
| ccr | output | 8 | Flag register, order in R2 |

## Verification
Every operation is swept over all 256 values of A against sixteen spread values of B. Before each carry-using operation, the register is written with a varying pattern so that both values of the incoming C occur. This catches a design that ignores or inverts the stored carry, and one that computes borrow with the wrong sense. Directed cases go after the 0x7F+1 and 0x80−1 overflow edges, after 0x0F+1 for half-carry, and after a zero result reached through a borrow. A design that lets logic operations or subtracts disturb H or C, or lets flags drift with the enable low, shows a register value that differs from the bench's running model. A design that lets an update override a same-cycle write shows the same kind of mismatch.

// File: rtl/alu8_pkg.sv
// Package: shared operation encoding and flag bit positions for the
// eight-bit ALU with condition code register. Assumes an 8-bit register.
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBC  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_PASS = 3'd7
    } alu_op_e;

    // Flag positions inside the condition code register (fixed order)
    localparam int CC_S = 7;
    localparam int CC_X = 6;
    localparam int CC_H = 5;
    localparam int CC_I = 4;
    localparam int CC_N = 3;
    localparam int CC_Z = 2;
    localparam int CC_V = 1;
    localparam int CC_C = 0;

    localparam int          CC_BITS  = 8;
    localparam logic [7:0]  CC_RESET = 8'hD0;

    // Bits any ALU operation may touch; control bits are never in here
    localparam logic [7:0] MASK_ADD   = 8'b0010_1111;
    localparam logic [7:0] MASK_SUB   = 8'b0000_1111;
    localparam logic [7:0] MASK_LOGIC = 8'b0000_1110;

endpackage

// File: rtl/alu8_arith.sv
// Module: adder/subtractor core. Subtraction is done as A + ~B + ~borrow,
// so the raw carry out is the inverse of the borrow. Produces the result,
// carry/borrow, signed overflow and the carry out of the low half.
// Assumes WIDTH is even and at least 4.
module alu8_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             is_sub,
    input  logic             use_cin,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             c_out,
    output logic             v_out,
    output logic             h_out
);
    localparam int HALF = WIDTH / 2;
    localparam int MSB  = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             c_in_eff;
    logic [WIDTH:0]   full;
    logic [HALF:0]    low;

    // Form the effective second operand and carry in for add or subtract
    always_comb begin
        b_eff    = is_sub ? ~b : b;
        c_in_eff = is_sub ? ~(use_cin & cin) : (use_cin & cin);
    end

    // Full-width sum and the low-half sum for the half-carry
    always_comb begin
        full = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_in_eff};
        low  = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]}
             + {{HALF{1'b0}}, c_in_eff};
    end

    // Flag outputs: borrow is the inverted carry on subtract
    always_comb begin
        res   = full[WIDTH-1:0];
        c_out = is_sub ? ~full[WIDTH] : full[WIDTH];
        v_out = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);
        h_out = low[HALF];
    end

endmodule

// File: rtl/alu8_logic.sv
// Module: bitwise unit. sel picks AND, OR, XOR or pass-through of A.
// Assumes sel is the low two bits of the operation code.
module alu8_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] res
);
    // Select the bitwise function
    always_comb begin
        case (sel)
            2'd0:    res = a & b;
            2'd1:    res = a | b;
            2'd2:    res = a ^ b;
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu8_ccr.sv
// Module: condition code register. A full write has priority over a masked
// flag update; bits outside the mask keep their value. Synchronous
// active-low reset to CC_RESET.
module alu8_ccr
    import alu8_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [CC_BITS-1:0] wdata,
    input  logic               upd,
    input  logic [CC_BITS-1:0] upd_mask,
    input  logic [CC_BITS-1:0] upd_val,
    output logic [CC_BITS-1:0] ccr_q
);
    logic [CC_BITS-1:0] ccr_d;

    // Next-state selection: reset, write, masked update, hold
    always_comb begin
        if (we)
            ccr_d = wdata;
        else if (upd)
            ccr_d = (ccr_q & ~upd_mask) | (upd_val & upd_mask);
        else
            ccr_d = ccr_q;
    end

    // Register the flags
    always_ff @(posedge clk) begin
        if (!rst_n)
            ccr_q <= CC_RESET;
        else
            ccr_q <= ccr_d;
    end

    // R9: no write and no update means the register holds
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !upd) |=> $stable(ccr_q));

    // R10: control bits move only by a write
    p_ctl_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(ccr_q[CC_S]) && $stable(ccr_q[CC_X]) && $stable(ccr_q[CC_I])));

    // R10: a write loads every bit, even with an update pending
    p_write_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ccr_q == $past(wdata)));

endmodule

// File: rtl/alu8_flagged.sv
// Module: top of the eight-bit ALU with condition code register. Routes
// operands to the arithmetic or logic unit, selects the result and builds
// the per-operation flag mask. Assumes op_sel encoding from alu8_pkg.
module alu8_flagged
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_sel,
    input  logic             flag_en,
    input  logic             ccr_we,
    input  logic [7:0]       ccr_wdata,
    output logic [WIDTH-1:0] result,
    output logic [7:0]       ccr
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op_e;
    logic             is_arith;
    logic             is_sub;
    logic             use_cin;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic             c_new;
    logic             v_new;
    logic             h_new;
    logic [7:0]       upd_mask;
    logic [7:0]       upd_val;

    // Decode the operation class
    always_comb begin
        op_e     = alu_op_e'(op_sel);
        is_arith = !op_sel[2];
        is_sub   = (op_e == OP_SUB) || (op_e == OP_SBC);
        use_cin  = (op_e == OP_ADC) || (op_e == OP_SBC);
    end

    alu8_arith #(.WIDTH(WIDTH)) u_arith (
        .a       (opnd_a),
        .b       (opnd_b),
        .is_sub  (is_sub),
        .use_cin (use_cin),
        .cin     (ccr[CC_C]),
        .res     (arith_res),
        .c_out   (c_new),
        .v_out   (v_new),
        .h_out   (h_new)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (op_sel[1:0]),
        .res (logic_res)
    );

    // Result select
    always_comb begin
        result = is_arith ? arith_res : logic_res;
    end

    // Flag values and the mask of flags this operation may write
    always_comb begin
        upd_val        = '0;
        upd_val[CC_N]  = result[MSB];
        upd_val[CC_Z]  = (result == '0);
        upd_val[CC_V]  = is_arith ? v_new : 1'b0;
        upd_val[CC_C]  = c_new;
        upd_val[CC_H]  = h_new;
        if (!is_arith)
            upd_mask = MASK_LOGIC;
        else if (is_sub)
            upd_mask = MASK_SUB;
        else
            upd_mask = MASK_ADD;
    end

    alu8_ccr u_ccr (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ccr_we),
        .wdata    (ccr_wdata),
        .upd      (flag_en),
        .upd_mask (upd_mask),
        .upd_val  (upd_val),
        .ccr_q    (ccr)
    );

    // R4: Z tracks a zero result after an update
    p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !ccr_we) |=> (ccr[CC_Z] == ($past(result) == '0)));

    // R8: logic operations clear V and keep C and H
    p_logic_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !ccr_we && op_sel[2]) |=>
            (!ccr[CC_V] && $stable(ccr[CC_C]) && $stable(ccr[CC_H])));

    // R6: plain subtract borrows exactly when B exceeds A
    p_sub_borrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !ccr_we && op_sel == 3'd2) |=>
            (ccr[CC_C] == ($past(opnd_b) > $past(opnd_a))));

    // R7: subtracts leave H alone
    p_sub_keeps_h_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !ccr_we && op_sel[2:1] == 2'b01) |=> $stable(ccr[CC_H]));

endmodule

// File: tb/sim_alu8_flagged.sv
module sim_alu8_flagged;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic [2:0] op_sel = 3'd0;
    logic       flag_en = 1'b0;
    logic       ccr_we = 1'b0;
    logic [7:0] ccr_wdata = 8'h00;
    logic [7:0] result;
    logic [7:0] ccr;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_ccr;
    logic [7:0] exp_res;

    always #2 clk = ~clk;

    alu8_flagged u0 (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sel(op_sel), .flag_en(flag_en), .ccr_we(ccr_we),
        .ccr_wdata(ccr_wdata), .result(result), .ccr(ccr)
    );

    // Reference model built from the requirements: {result, new flags}
    function automatic logic [15:0] model(input int op, input int a, input int b,
                                          input logic [7:0] cc);
        logic [7:0] n = cc;
        int r, cin, res;
        case (op)
            0, 1: begin
                cin  = (op == 1) ? int'(cc[0]) : 0;
                r    = a + b + cin;
                res  = r & 255;
                n[0] = (r > 255);
                n[5] = (((a & 15) + (b & 15) + cin) > 15);
                n[1] = ((a >= 128) == (b >= 128)) && ((res >= 128) != (a >= 128));
            end
            2, 3: begin
                cin  = (op == 3) ? int'(cc[0]) : 0;
                r    = a - b - cin;
                res  = r & 255;
                n[0] = ((b + cin) > a);
                n[1] = ((a >= 128) != (b >= 128)) && ((res >= 128) != (a >= 128));
            end
            4: begin res = a & b; n[1] = 1'b0; end
            5: begin res = a | b; n[1] = 1'b0; end
            6: begin res = a ^ b; n[1] = 1'b0; end
            default: begin res = a; n[1] = 1'b0; end
        endcase
        n[3] = (res >= 128);
        n[2] = (res == 0);
        return {res[7:0], n};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive one operation; check result before the edge, flags after it
    task automatic do_op(input int op, input int a, input int b, input logic fe,
                         input string req);
        logic [15:0] m;
        @(negedge clk);
        op_sel = 3'(op); opnd_a = 8'(a); opnd_b = 8'(b); flag_en = fe; ccr_we = 1'b0;
        m = model(op, a, b, exp_ccr);
        #1;
        check({req, " result (R3)"}, result, m[15:8]);
        if (fe) exp_ccr = m[7:0];
        @(posedge clk); #1;
        check({req, " flags"}, ccr, exp_ccr);
        flag_en = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] v, input logic fe, input string req);
        @(negedge clk);
        ccr_we = 1'b1; ccr_wdata = v; flag_en = fe;
        op_sel = 3'd0; opnd_a = 8'h7F; opnd_b = 8'h01;
        exp_ccr = v;
        @(posedge clk); #1;
        check(req, ccr, exp_ccr);
        ccr_we = 1'b0; flag_en = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        exp_ccr = 8'hD0;
        check("R1 reset value", ccr, exp_ccr);
        @(negedge clk); rst_n = 1'b1;

        // R2/R4/R5/R7 directed edges: bit positions S X H I N Z V C
        do_op(0, 8'h7F, 8'h01, 1'b1, "R5 R7 R2 7F+01 overflow half-carry");
        check("R2 flag positions", ccr, 8'hFA);
        do_op(2, 8'h80, 8'h01, 1'b1, "R5 80-01 overflow");
        do_op(0, 8'hFF, 8'h01, 1'b1, "R6 R4 FF+01 carry zero");
        do_write(8'hD1, 1'b0, "R10 write C set");
        do_op(3, 8'h00, 8'h00, 1'b1, "R11 R6 borrow-in 00-00-1");
        do_op(2, 8'h05, 8'h05, 1'b1, "R4 zero via subtract");
        do_op(0, 8'h0F, 8'h01, 1'b1, "R7 0F+01 half-carry");
        do_op(5, 8'h80, 8'h00, 1'b1, "R8 logic clears V keeps C H");

        // R9: enable low, flags hold
        do_op(0, 8'hFF, 8'hFF, 1'b0, "R9 hold with enable low");
        do_op(6, 8'h00, 8'h00, 1'b0, "R9 hold logic enable low");

        // R10: write wins over a same-cycle update; control bits only by write
        do_write(8'h0A, 1'b1, "R10 write priority");
        do_op(0, 8'h80, 8'h80, 1'b1, "R10 control bits stay clear");
        do_write(8'hFF, 1'b0, "R10 full write");
        do_op(4, 8'h00, 8'hFF, 1'b1, "R10 control bits stay set");

        // Sweep: every op, all A, sixteen spread B; carry ops preloaded
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b += 17) begin
                    if (op == 1 || op == 3 || ((a + b) % 7 == 0))
                        do_write(8'(a ^ (b * 3) ^ op), 1'b0, "R10 sweep write");
                    do_op(op, a, b, 1'b1, "R3 R4 R5 R6 R7 R8 R11 sweep");
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule